// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link for a part organised as 16-bit words. It owns the select, clock and data-out pins toward the memory and samples the memory's data-out pin. The user side is a one-shot command port. An opcode, an address, a write word and a word count are presented with a start pulse, and the controller answers with a one-cycle done pulse. Read words come back one at a time on a data bus with a valid strobe, and an error flag reports a busy poll that ran out of time. The serial clock is derived from the system clock by a parameterised half-period counter, so the same RTL can meet the memory's 2 MHz ceiling and its 0.25 us minimum high and low times at any system clock rate.

The controller is one state machine with six states. S_IDLE leaves on a start pulse with a valid opcode and goes to S_SEND. S_SEND shifts out the frame and then goes to S_READ for a read, to S_GAP for a program-type command (write, erase, erase-all, write-all), or back to S_IDLE for write-enable and write-disable. S_READ assembles words and returns to S_IDLE after the last one. S_GAP holds select low and moves to S_POLL. S_POLL goes to S_RELEASE on ready, or to S_IDLE on timeout. S_RELEASE clocks one dummy bit and returns to S_IDLE. The memory accepts erase or write only after a write-enable command, so software issues that command first after power-up.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, and at any time `busy` is low, `mw_cs` and `mw_sk` are low, and `cmd_done` and `cmd_error` are low after reset.
- R2: Each frame is sent MSB first: a 1, a 2-bit code, 8 address bits, then 16 data bits for `cmd_op` 1 (write) and 6 (write-all). The codes are: read (`cmd_op` 0) 10, write 01, erase (`cmd_op` 2) 11. The other commands use code 00 with a subcode in address bits 7:6 and zeros below: enable (`cmd_op` 3) 11, disable (`cmd_op` 4) 00, erase-all (`cmd_op` 5) 10, write-all 01.
- R3: `mw_di` changes only in the cycle where `mw_sk` falls or while the clock is stopped, and it is stable across every rising edge of `mw_sk`.
- R4: While running, every high and low phase of `mw_sk` lasts exactly SK_HALF system cycles, and `mw_sk` is high only while `mw_cs` is high.
- R5: On a read, the bit present after the last address bit is discarded. The next 16 bits, sampled while `mw_sk` is high, form one word, MSB first, presented on `rd_data` with a one-cycle `rd_valid` pulse.
- R6: A read with `cmd_count` N returns N consecutive words from one address phase, with `mw_cs` held high throughout. The address wraps from 255 to 0. A count of 0 returns one word.
- R7: After a program-type frame, `mw_cs` is low for exactly CS_GAP cycles, then high while `mw_do` is polled.
- R8: When `mw_do` is seen high, one extra rising edge of `mw_sk` is sent with `mw_di` = 1. Then `mw_cs` drops and `cmd_done` pulses for exactly one cycle. Every command ends with one such pulse.
- R9: If `mw_do` stays low for POLL_LIMIT cycles, `mw_cs` drops and `cmd_error` rises with `cmd_done`. `cmd_error` stays high until the next accepted start.
- R10: Enable and disable commands end right after their frame, with no CS-low gap, no poll and no dummy bit.
- R11: `cmd_start` is ignored while `busy` is high and when `cmd_op` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_op | input | 3 | Command select (encoding in R2) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word for write and write-all |
| cmd_count | input | ADDR_W | Read word count (0 means 1) |
| cmd_start | input | 1 | One-cycle command request |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_error | output | 1 | Busy-poll timeout flag |
| rd_data | output | DATA_W | Last read word |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | Command in progress |
| mw_cs | output | 1 | Memory chip select |
| mw_sk | output | 1 | Memory serial clock |
| mw_di | output | 1 | Serial data toward the memory |
| mw_do | input | 1 | Serial data from the memory |

## Verification
The assertions assume that `mw_do` is a synchronous input that a memory changes only after a rising edge of `mw_sk`, or while select is high in the status window. They also assume that `cmd_start` is a single-cycle request with the command fields held steady in that cycle. The bench meets both conditions. Its memory model is evaluated once per system cycle at the falling clock edge, it updates its output half a system cycle after seeing a serial clock rise, and SK_HALF is set to 3 so the change settles well before the controller samples. Commands are driven from tasks on the falling clock edge, with start held for exactly one cycle.

// File: rtl/mw_host_pkg.sv
`timescale 1ns/1ps
package mw_host_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4,
        OP_FILL1 = 3'd5,
        OP_FILLD = 3'd6
    } mw_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SEND, S_READ, S_GAP, S_POLL, S_RELEASE
    } mw_state_e;

    localparam logic [1:0] CODE_SPECIAL = 2'b00;
    localparam logic [1:0] CODE_WRITE   = 2'b01;
    localparam logic [1:0] CODE_READ    = 2'b10;
    localparam logic [1:0] CODE_ERASE   = 2'b11;

    localparam logic [1:0] SUB_DISABLE  = 2'b00;
    localparam logic [1:0] SUB_FILLD    = 2'b01;
    localparam logic [1:0] SUB_FILL1    = 2'b10;
    localparam logic [1:0] SUB_ENABLE   = 2'b11;
endpackage

// File: rtl/mw_sk_gen.sv
`timescale 1ns/1ps
// Serial clock divider: each phase lasts HALF system cycles while run is high.
module mw_sk_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          tc;

    assign tc   = (cnt_q == CW'(HALF - 1));
    assign rise = run && tc && !sk;
    assign fall = run && tc && sk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sk    <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sk    <= 1'b0;
        end else if (tc) begin
            cnt_q <= '0;
            sk    <= ~sk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mw_frame_build.sv
`timescale 1ns/1ps
// Builds the left-aligned outgoing frame and classifies the command.
module mw_frame_build
    import mw_host_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [2:0]                          op,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [3+ADDR_W+DATA_W-1:0]          frame,
    output logic [$clog2(4+ADDR_W+DATA_W)-1:0]  len,
    output logic                                is_read,
    output logic                                is_prog
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int HDR_W   = 3 + ADDR_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic [1:0]        code;
    logic [ADDR_W-1:0] field;
    logic              with_data;

    always_comb begin
        code      = CODE_SPECIAL;
        field     = '0;
        with_data = 1'b0;
        is_read   = 1'b0;
        is_prog   = 1'b0;
        unique case (op)
            OP_READ:  begin code = CODE_READ;  field = addr; is_read = 1'b1; end
            OP_WRITE: begin code = CODE_WRITE; field = addr; with_data = 1'b1; is_prog = 1'b1; end
            OP_ERASE: begin code = CODE_ERASE; field = addr; is_prog = 1'b1; end
            OP_WREN:  field = {SUB_ENABLE,  {(ADDR_W-2){1'b0}}};
            OP_WRDIS: field = {SUB_DISABLE, {(ADDR_W-2){1'b0}}};
            OP_FILL1: begin field = {SUB_FILL1, {(ADDR_W-2){1'b0}}}; is_prog = 1'b1; end
            OP_FILLD: begin
                field = {SUB_FILLD, {(ADDR_W-2){1'b0}}};
                with_data = 1'b1;
                is_prog = 1'b1;
            end
            default: ;
        endcase
        frame = {1'b1, code, field, (with_data ? wdata : {DATA_W{1'b0}})};
        len   = with_data ? LEN_W'(FRAME_W) : LEN_W'(HDR_W);
    end
endmodule

// File: rtl/mw_eeprom_host.sv
`timescale 1ns/1ps
module mw_eeprom_host
    import mw_host_pkg::*;
#(
    parameter int SK_HALF    = 4,
    parameter int CS_GAP     = 10,
    parameter int POLL_LIMIT = 4000,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [ADDR_W-1:0] cmd_count,
    input  logic              cmd_start,
    output logic              cmd_done,
    output logic              cmd_error,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_di,
    input  logic              mw_do
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int RB_W    = $clog2(DATA_W);
    localparam int GAP_W   = $clog2(CS_GAP + 1);
    localparam int POLL_W  = $clog2(POLL_LIMIT + 1);

    mw_state_e state_q, state_d;

    logic [FRAME_W-1:0] frame_w, sr_q;
    logic [LEN_W-1:0]   len_w, len_q, sent_q;
    logic               is_read_w, is_prog_w, is_read_q, is_prog_q;
    logic               run_q, sk_rise, sk_fall;
    logic [RB_W-1:0]    rbit_q;
    logic [DATA_W-1:0]  rsh_q;
    logic [ADDR_W-1:0]  words_q;
    logic [GAP_W-1:0]   gap_q;
    logic [POLL_W-1:0]  poll_q;
    logic               start_ok, frame_end, word_end;

    mw_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .op(cmd_op), .addr(cmd_addr), .wdata(cmd_wdata),
        .frame(frame_w), .len(len_w), .is_read(is_read_w), .is_prog(is_prog_w)
    );

    mw_sk_gen #(.HALF(SK_HALF)) u_sk (
        .clk(clk), .rst_n(rst_n), .run(run_q),
        .sk(mw_sk), .rise(sk_rise), .fall(sk_fall)
    );

    assign start_ok  = cmd_start && (cmd_op != 3'd7);
    assign frame_end = sk_fall && (sent_q == len_q);
    assign word_end  = sk_fall && (rbit_q == RB_W'(DATA_W - 1));
    assign busy      = (state_q != S_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_ok) state_d = S_SEND;
            S_SEND:    if (frame_end) state_d = is_read_q ? S_READ : (is_prog_q ? S_GAP : S_IDLE);
            S_READ:    if (word_end && words_q == ADDR_W'(1)) state_d = S_IDLE;
            S_GAP:     if (gap_q == GAP_W'(CS_GAP - 1)) state_d = S_POLL;
            S_POLL:    if (mw_do) state_d = S_RELEASE;
                       else if (poll_q == POLL_W'(POLL_LIMIT - 1)) state_d = S_IDLE;
            S_RELEASE: if (sk_fall) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Pins and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mw_cs <= 1'b0; mw_di <= 1'b0; run_q <= 1'b0;
            cmd_done <= 1'b0; cmd_error <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
            sr_q <= '0; len_q <= '0; sent_q <= '0; is_read_q <= 1'b0; is_prog_q <= 1'b0;
            rbit_q <= '0; rsh_q <= '0; words_q <= '0; gap_q <= '0; poll_q <= '0;
        end else begin
            cmd_done <= 1'b0;
            rd_valid <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_ok) begin
                    mw_cs     <= 1'b1;
                    run_q     <= 1'b1;
                    mw_di     <= frame_w[FRAME_W-1];
                    sr_q      <= frame_w << 1;
                    len_q     <= len_w;
                    sent_q    <= '0;
                    is_read_q <= is_read_w;
                    is_prog_q <= is_prog_w;
                    words_q   <= (cmd_count == '0) ? ADDR_W'(1) : cmd_count;
                    cmd_error <= 1'b0;
                end
                S_SEND: begin
                    if (sk_rise) sent_q <= sent_q + 1'b1;
                    if (frame_end) begin
                        mw_di <= 1'b0;
                        if (is_read_q) begin
                            rbit_q <= '0;          // dummy bit dropped here
                        end else begin
                            run_q <= 1'b0;
                            mw_cs <= 1'b0;
                            gap_q <= '0;
                            if (!is_prog_q) cmd_done <= 1'b1;
                        end
                    end else if (sk_fall) begin
                        mw_di <= sr_q[FRAME_W-1];
                        sr_q  <= sr_q << 1;
                    end
                end
                S_READ: if (sk_fall) begin
                    rsh_q  <= {rsh_q[DATA_W-2:0], mw_do};
                    rbit_q <= rbit_q + 1'b1;
                    if (word_end) begin
                        rd_data  <= {rsh_q[DATA_W-2:0], mw_do};
                        rd_valid <= 1'b1;
                        rbit_q   <= '0;
                        if (words_q == ADDR_W'(1)) begin
                            run_q    <= 1'b0;
                            mw_cs    <= 1'b0;
                            cmd_done <= 1'b1;
                        end else begin
                            words_q <= words_q - 1'b1;
                        end
                    end
                end
                S_GAP: begin
                    gap_q <= gap_q + 1'b1;
                    if (gap_q == GAP_W'(CS_GAP - 1)) begin
                        mw_cs  <= 1'b1;
                        poll_q <= '0;
                    end
                end
                S_POLL: begin
                    if (mw_do) begin
                        mw_di <= 1'b1;
                        run_q <= 1'b1;
                    end else begin
                        poll_q <= poll_q + 1'b1;
                        if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
                            mw_cs     <= 1'b0;
                            cmd_error <= 1'b1;
                            cmd_done  <= 1'b1;
                        end
                    end
                end
                S_RELEASE: if (sk_fall) begin
                    run_q    <= 1'b0;
                    mw_cs    <= 1'b0;
                    mw_di    <= 1'b0;
                    cmd_done <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mw_eeprom_host_chk.sv
`timescale 1ns/1ps
module mw_eeprom_host_chk #(
    parameter int SK_HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic mw_cs,
    input logic mw_sk,
    input logic mw_di,
    input logic cmd_done,
    input logic cmd_error,
    input logic rd_valid,
    input logic busy
);
    int hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_len <= 0;
        else        hi_len <= mw_sk ? hi_len + 1 : 0;
    end

    a_r1_idle_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mw_cs && !mw_sk));

    a_r3_di_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_sk) |-> $stable(mw_di));

    a_r4_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mw_sk) |-> (hi_len == SK_HALF));

    a_r4_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mw_cs |-> !mw_sk);

    a_r5_valid_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mw_cs || cmd_done));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    a_r9_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_error) |-> cmd_done);
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.SK_HALF(SK_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di),
    .cmd_done(cmd_done), .cmd_error(cmd_error), .rd_valid(rd_valid), .busy(busy)
);

// File: tb/mw_eeprom_host_test.sv
`timescale 1ns/1ps
module mw_eeprom_host_test;
    localparam int SK_HALF = 3, CS_GAP = 5, POLL_LIMIT = 60, BUSY_CYC = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_addr = 8'd0, cmd_count = 8'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic        cmd_start = 1'b0;
    logic        cmd_done, cmd_error, rd_valid, busy, mw_cs, mw_sk, mw_di, mw_do;
    logic [15:0] rd_data;

    mw_eeprom_host #(.SK_HALF(SK_HALF), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_count(cmd_count), .cmd_start(cmd_start), .cmd_done(cmd_done), .cmd_error(cmd_error),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
    );

    int checks = 0, failures = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory model, evaluated once per cycle
    logic [15:0] mem [0:255];
    bit wen = 0, stuck = 0, status_mode = 0, want_status = 0;
    bit started = 0, complete = 0, reading = 0, do_bit = 0;
    int busy_left = 0, nbits = 0, raddr = 0, rpos = 0, pend = 0;
    int status_exits = 0, ncmd = 0, cs_rises = 0, low_len = 0, last_gap = 0, hi_len = 0;
    logic [25:0] hdr = '0;
    logic [1:0]  last_code = '0;
    logic [7:0]  last_addr = '0;
    logic [15:0] last_data = '0;
    logic sk_prev = 0, cs_prev = 0, di_prev = 0;
    logic [15:0] rdq[$];

    assign mw_do = (mw_cs && status_mode) ? (busy_left == 0 && !stuck)
                 : ((mw_cs && reading) ? do_bit : 1'b0);

    task automatic dev_rise();
        if (status_mode) begin
            if (mw_di) begin status_mode = 0; status_exits++; end
        end else if (reading) begin
            if (rpos == 16) begin raddr = (raddr + 1) % 256; rpos = 0; end
            do_bit = mem[raddr][15-rpos];
            rpos++;
        end else if (complete) begin
        end else if (!started) begin
            if (mw_di) begin started = 1; nbits = 0; hdr = '0; end
        end else begin
            hdr = {hdr[24:0], mw_di};
            nbits++;
            if (nbits == 10) begin
                last_code = hdr[9:8]; last_addr = hdr[7:0];
                if (hdr[9:8] == 2'b10) begin
                    reading = 1; raddr = hdr[7:0]; rpos = 0; do_bit = 0; complete = 1; ncmd++;
                end else if (hdr[9:8] == 2'b11) begin
                    pend = 2; complete = 1; ncmd++;
                end else if (hdr[9:8] == 2'b00 && hdr[7:6] != 2'b01) begin
                    if (hdr[7:6] == 2'b11) wen = 1;
                    if (hdr[7:6] == 2'b00) wen = 0;
                    if (hdr[7:6] == 2'b10) pend = 3;
                    complete = 1; ncmd++;
                end
            end else if (nbits == 26) begin
                last_code = hdr[25:24]; last_addr = hdr[23:16]; last_data = hdr[15:0];
                pend = (hdr[25:24] == 2'b01) ? 1 : 4;
                complete = 1; ncmd++;
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mw_sk && !sk_prev)
                check(mw_di === di_prev, "R3", "DI moved at SK rise", mw_di, di_prev);
            if (mw_sk) hi_len++;
            else begin
                if (sk_prev) check(hi_len == SK_HALF, "R4", "SK high phase", hi_len, SK_HALF);
                hi_len = 0;
            end
            if (mw_cs && !cs_prev) begin
                cs_rises++; last_gap = low_len; low_len = 0;
                if (want_status) begin status_mode = 1; want_status = 0; end
            end else if (!mw_cs) low_len++;
            if (!mw_cs && cs_prev) begin
                if (pend != 0) begin
                    if (wen) begin
                        for (int i = 0; i < 256; i++) begin
                            if (pend == 3 || (pend == 2 && i == last_addr)) mem[i] = 16'hFFFF;
                            if (pend == 4 || (pend == 1 && i == last_addr)) mem[i] = last_data;
                        end
                        busy_left = BUSY_CYC;
                    end
                    want_status = 1;
                end
                started = 0; complete = 0; reading = 0; pend = 0; nbits = 0; status_mode = 0;
            end
            if (mw_cs && mw_sk && !sk_prev) dev_rise();
            if (busy_left > 0) busy_left--;
            if (rd_valid) rdq.push_back(rd_data);
        end
        sk_prev = mw_sk; cs_prev = mw_cs; di_prev = mw_di;
    end

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] a,
                           input logic [15:0] d, input logic [7:0] n);
        @(negedge clk);
        rdq.delete(); cs_rises = 0;
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_count = n; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        begin
            int w = 0;
            while (!cmd_done && w < 20000) begin @(negedge clk); w++; end
            check(w < 20000, "R8", "command completion", w, 0);
        end
        @(negedge clk);
        check(!cmd_done, "R8", "done lasts one cycle", cmd_done, 0);
    endtask

    task automatic read_one(input logic [7:0] a, input logic [15:0] exp, input string req);
        run_cmd(3'd0, a, 16'h0, 8'd1);
        check(rdq.size() == 1, req, "read word count", rdq.size(), 1);
        if (rdq.size() >= 1) check(rdq[0] == exp, req, "read data", rdq[0], exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ex, nc;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5555;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!mw_cs && !mw_sk && !cmd_done && !cmd_error && !busy, "R1", "reset pins",
              {mw_cs, mw_sk, cmd_done, cmd_error, busy}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mw_cs && !busy, "R1", "idle after reset", {mw_cs, busy}, 0);

        // R2 write frame while memory is write-disabled
        run_cmd(3'd1, 8'h10, 16'h1234, 8'd0);
        check(last_code == 2'b01 && last_addr == 8'h10, "R2", "write header", {last_code, last_addr}, 10'h110);
        check(last_data == 16'h1234, "R2", "write data field", last_data, 16'h1234);
        read_one(8'h10, 16'h4545, "R2");

        // R10 enable: no gap, no poll
        ex = status_exits;
        run_cmd(3'd3, 8'h00, 16'h0, 8'd0);
        check(wen == 1 && last_code == 2'b00 && last_addr == 8'hC0, "R10", "enable decoded", last_addr, 8'hC0);
        check(cs_rises == 1 && status_exits == ex, "R10", "enable single select, no poll", cs_rises, 1);

        // R7 / R8 program write
        ex = status_exits;
        run_cmd(3'd1, 8'h10, 16'hBEEF, 8'd0);
        check(last_gap == CS_GAP, "R7", "CS low gap", last_gap, CS_GAP);
        check(cs_rises == 2, "R7", "CS reasserted for poll", cs_rises, 2);
        check(status_exits == ex + 1, "R8", "dummy 1 released DO", status_exits - ex, 1);
        check(!cmd_error, "R8", "no error on ready", cmd_error, 0);
        read_one(8'h10, 16'hBEEF, "R5");

        // R6 burst with wrap
        run_cmd(3'd1, 8'hFF, 16'h1111, 8'd0);
        run_cmd(3'd1, 8'h00, 16'h2222, 8'd0);
        run_cmd(3'd1, 8'hFE, 16'h3333, 8'd0);
        run_cmd(3'd0, 8'hFE, 16'h0, 8'd4);
        check(rdq.size() == 4, "R6", "burst word count", rdq.size(), 4);
        check(cs_rises == 1, "R6", "single select in burst", cs_rises, 1);
        if (rdq.size() == 4) begin
            check(rdq[0] == 16'h3333, "R6", "burst word0", rdq[0], 16'h3333);
            check(rdq[1] == 16'h1111, "R6", "burst word1", rdq[1], 16'h1111);
            check(rdq[2] == 16'h2222, "R6", "burst word2 wrap", rdq[2], 16'h2222);
            check(rdq[3] == 16'h5454, "R6", "burst word3", rdq[3], 16'h5454);
        end
        run_cmd(3'd0, 8'h10, 16'h0, 8'd0);
        check(rdq.size() == 1, "R6", "count 0 gives one word", rdq.size(), 1);

        // R2 erase, erase-all, write-all
        run_cmd(3'd2, 8'h00, 16'h0, 8'd0);
        check(last_code == 2'b11 && last_addr == 8'h00, "R2", "erase header", {last_code, last_addr}, 10'h300);
        read_one(8'h00, 16'hFFFF, "R2");
        run_cmd(3'd5, 8'h00, 16'h0, 8'd0);
        check(last_code == 2'b00 && last_addr == 8'h80, "R2", "erase-all subcode", last_addr, 8'h80);
        read_one(8'h10, 16'hFFFF, "R2");
        run_cmd(3'd6, 8'h00, 16'h5A3C, 8'd0);
        check(last_addr == 8'h40 && last_data == 16'h5A3C, "R2", "write-all frame", last_addr, 8'h40);
        read_one(8'h80, 16'h5A3C, "R5");

        // R10 disable
        run_cmd(3'd4, 8'h00, 16'h0, 8'd0);
        check(wen == 0 && last_addr == 8'h00 && cs_rises == 1, "R10", "disable decoded", wen, 0);
        run_cmd(3'd1, 8'h80, 16'h0000, 8'd0);
        read_one(8'h80, 16'h5A3C, "R2");

        // R9 timeout
        run_cmd(3'd3, 8'h00, 16'h0, 8'd0);
        stuck = 1;
        run_cmd(3'd1, 8'h20, 16'h7777, 8'd0);
        check(cmd_error == 1, "R9", "error after timeout", cmd_error, 1);
        check(!mw_cs && !busy, "R9", "idle with CS low", {mw_cs, busy}, 0);
        stuck = 0;
        repeat (30) @(negedge clk);
        check(cmd_error == 1, "R9", "error held", cmd_error, 1);
        read_one(8'h20, 16'h7777, "R9");
        check(cmd_error == 0, "R9", "error cleared by start", cmd_error, 0);

        // R11 start ignored while busy
        nc = ncmd;
        @(negedge clk);
        cmd_op = 3'd0; cmd_addr = 8'h10; cmd_count = 8'd1; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        repeat (5) @(negedge clk);
        cmd_op = 3'd4; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        check(ncmd == nc + 1 && wen == 1, "R11", "start during busy ignored", ncmd - nc, 1);

        // R11 opcode 7 ignored
        cs_rises = 0;
        cmd_op = 3'd7; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        repeat (50) @(negedge clk);
        check(!busy && cs_rises == 0, "R11", "opcode 7 ignored", cs_rises, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule